// File: doc/BRIEF.md
# Indirect Host Register Access Bridge

This block is the host-bus front end of a memory-mapped network controller. A host issues single-cycle byte strobes (chip select, write enable, address, write data) and the bridge steers each one into the controller's internal 15-bit byte address space. That space holds three kinds of target. Internal address 0 is the mode register, which the bridge keeps itself. A small bank of common registers sits just above it and is also held inside the bridge. Every higher address goes out on a byte port to the buffer RAM and the rest of the register file, which are modelled outside the block as a synchronous byte memory.

The bridge has two access schemes, and bit 0 of the mode register selects between them. In direct mode the host address is the internal address, so the block fills 0x8000 bytes of host space. In indirect mode only the two low host address bits are decoded. Offset 0 is still the mode register. Offsets 1 and 2 hold the high and low bytes of a latched internal address. Offset 3 is a data port that reaches the byte at that address. When auto-increment (mode bit 1) is set, every data-port access moves the address up by one. Software can then stream a buffer, or fetch a big-endian 16-bit register as two reads in a row.

Setting mode bit 7 starts a software reset. The mode register, the address latch and the register bank return to their defaults at once. Bit 7 then reads back as 1 for a fixed number of cycles before it clears. Mode bit 4 (ping blocking) is only held and driven out to the rest of the controller.

Top module: `hostwin_bridge`

## Requirements
- R1: After hardware reset the mode register reads 0x00, so the bridge is in direct mode. The retry-time register reads 0x07 at internal address 0x0017 and 0xD0 at 0x0018.
- R2: Host offset 0 reaches the mode register in both schemes. Only bits 7 (reset), 4 (ping block), 1 (auto-increment) and 0 (indirect) are stored. Every other bit reads 0. The ping_block output follows bit 4.
- R3: In direct mode, internal address = host address. Address 0 is the mode register. Addresses 1 to 63 are the internal register bank. Addresses 64 and up strobe exactly one of ext_we or ext_re, only in the cycle of host_cs, with ext_addr equal to the internal address.
- R4: In indirect mode, offset 1 holds internal address bits 14:8 and offset 2 holds bits 7:0. Both read back what was written, and bit 7 of offset 1 always reads 0.
- R5: In indirect mode, offset 3 reads or writes the byte at the latched address. With auto-increment off, the latched address does not change. Without a host strobe it never changes.
- R6: With auto-increment on, each data-port read or write advances the latched address by one, and 0x7FFF wraps to 0x0000. Two reads in a row starting at 0x0017 return 0x07 and then 0xD0, high byte first.
- R7: In indirect mode, host address bits above bit 1 are ignored.
- R8: A write to offset 1 or 2 takes effect for a data-port access in the very next cycle.
- R9: Writing the mode register with bit 7 set does the following. It returns the mode register, the address latch and the register bank to their reset values. Bit 7 and core_rst read 1 for 4 cycles (RST_CYCLES) and then clear. Host writes during that window are ignored, while reads are still served.
- R10: Read data appears on host_rdata in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs | input | 1 | Host byte access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Host byte address (only bits 1:0 decoded in indirect mode) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid the cycle after a read strobe |
| ext_re | output | 1 | Read strobe to the internal buffer/register space |
| ext_we | output | 1 | Write strobe to the internal buffer/register space |
| ext_addr | output | 15 | Internal byte address for ext_re / ext_we |
| ext_wdata | output | 8 | Write byte to the internal space |
| ext_rdata | input | 8 | Byte returned by the internal space one cycle after ext_re |
| ping_block | output | 1 | Mode bit 4, drives ping blocking in the controller |
| core_rst | output | 1 | High while a software reset is in progress |

## Verification
The bench goes after the corner cases where an address is handled wrongly.
- The address latch wraps from 0x7FFF to address 0, where the data port reaches the mode register itself. A latch that saturated, or one that grew a sixteenth bit, would read back nonzero.
- An address write is followed at once by a data-port read. A latch that updated one cycle late would return the byte at the stale address.
- Indirect accesses are made with junk in the upper host address bits. A decoder that used those bits would land in the wrong target.
- The software reset is probed in the middle of the window with a write that must be dropped. A bridge that accepted it, that failed to restore the retry-time bytes after they had been overwritten, or that cleared bit 7 early would show the wrong value.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
    typedef enum logic [2:0] {
        K_MODE,
        K_AHI,
        K_ALO,
        K_BANK,
        K_EXT
    } kind_e;

    localparam int MB_RST   = 7;
    localparam int MB_NOPNG = 4;
    localparam int MB_AINC  = 1;
    localparam int MB_IND   = 0;

    // bits a plain mode write may set (reset bit handled separately)
    localparam logic [7:0] MODE_WMASK = 8'h13;
    localparam logic [1:0] OFS_MODE = 2'd0;
    localparam logic [1:0] OFS_AHI  = 2'd1;
    localparam logic [1:0] OFS_ALO  = 2'd2;
    localparam logic [1:0] OFS_PORT = 2'd3;
endpackage

// File: rtl/hwb_decode.sv
module hwb_decode
    import hwb_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int BANK_BYTES = 64
) (
    input  logic              indirect,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [ADDR_W-1:0] iaddr,
    output kind_e             kind,
    output logic [ADDR_W-1:0] tgt,
    output logic              is_port
);
    localparam logic [ADDR_W-1:0] BANK_TOP = ADDR_W'(BANK_BYTES);

    function automatic kind_e classify(input logic [ADDR_W-1:0] a);
        if (a == '0)
            return K_MODE;
        else if (a < BANK_TOP)
            return K_BANK;
        else
            return K_EXT;
    endfunction

    always_comb begin
        tgt     = host_addr;
        is_port = 1'b0;
        kind    = classify(host_addr);
        if (indirect) begin
            unique case (host_addr[1:0])
                OFS_MODE: begin tgt = '0; kind = K_MODE; end
                OFS_AHI:  kind = K_AHI;
                OFS_ALO:  kind = K_ALO;
                default: begin
                    tgt     = iaddr;
                    is_port = 1'b1;
                    kind    = classify(iaddr);
                end
            endcase
        end
    end
endmodule

// File: rtl/hwb_regbank.sv
module hwb_regbank #(
    parameter int          DEPTH     = 64,
    parameter int          RETRY_IDX = 23,
    parameter logic [15:0] RETRY_VAL = 16'h07D0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata
);
    logic [7:0] regs_d [DEPTH];
    logic [7:0] regs_q [DEPTH];

    // big-endian: high byte at the lower index
    function automatic logic [7:0] dflt(input int i);
        if (i == RETRY_IDX)
            return RETRY_VAL[15:8];
        else if (i == RETRY_IDX + 1)
            return RETRY_VAL[7:0];
        else
            return 8'h00;
    endfunction

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (clr)
                regs_d[i] = dflt(i);
            else if (we && idx == $clog2(DEPTH)'(i))
                regs_d[i] = wdata;
            else
                regs_d[i] = regs_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs_q[i] <= dflt(i);
        end else begin
            for (int i = 0; i < DEPTH; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rdata = regs_q[idx];
endmodule

// File: rtl/hostwin_bridge.sv
module hostwin_bridge
    import hwb_pkg::*;
#(
    parameter int          ADDR_W     = 15,
    parameter int          BANK_BYTES = 64,
    parameter int          RETRY_ADDR = 23,
    parameter logic [15:0] RETRY_VAL  = 16'h07D0,
    parameter int          RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              ext_re,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [7:0]        ext_wdata,
    input  logic [7:0]        ext_rdata,
    output logic              ping_block,
    output logic              core_rst
);
    localparam int HI_W   = ADDR_W - 8;
    localparam int CNT_W  = $clog2(RST_CYCLES + 1);
    localparam int BANK_W = $clog2(BANK_BYTES);

    typedef struct packed {
        logic [7:0]        mode;
        logic [ADDR_W-1:0] iaddr;
        logic [CNT_W-1:0]  rst_cnt;
        logic [7:0]        rd_byte;
        logic              rd_ext;
    } state_t;

    state_t st_d, st_q;

    kind_e             kind;
    logic [ADDR_W-1:0] tgt;
    logic              is_port;
    logic [7:0]        bank_rdata;
    logic              bank_we;
    logic              bank_clr;
    logic              busy;

    hwb_decode #(
        .ADDR_W     (ADDR_W),
        .BANK_BYTES (BANK_BYTES)
    ) u_dec (
        .indirect  (st_q.mode[MB_IND]),
        .host_addr (host_addr),
        .iaddr     (st_q.iaddr),
        .kind      (kind),
        .tgt       (tgt),
        .is_port   (is_port)
    );

    hwb_regbank #(
        .DEPTH     (BANK_BYTES),
        .RETRY_IDX (RETRY_ADDR),
        .RETRY_VAL (RETRY_VAL)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (bank_clr),
        .we    (bank_we),
        .idx   (tgt[BANK_W-1:0]),
        .wdata (host_wdata),
        .rdata (bank_rdata)
    );

    assign busy = (st_q.rst_cnt != '0);

    always_comb begin
        st_d     = st_q;
        bank_we  = 1'b0;
        bank_clr = 1'b0;
        ext_re   = 1'b0;
        ext_we   = 1'b0;

        // software reset countdown; bit 7 drops on the last cycle
        if (busy) begin
            st_d.rst_cnt = st_q.rst_cnt - 1'b1;
            if (st_q.rst_cnt == CNT_W'(1))
                st_d.mode[MB_RST] = 1'b0;
        end

        if (host_cs && !host_we) begin
            st_d.rd_ext = (kind == K_EXT);
            ext_re      = (kind == K_EXT);
            unique case (kind)
                K_MODE:  st_d.rd_byte = st_q.mode;
                K_AHI:   st_d.rd_byte = 8'(st_q.iaddr[ADDR_W-1:8]);
                K_ALO:   st_d.rd_byte = st_q.iaddr[7:0];
                K_BANK:  st_d.rd_byte = bank_rdata;
                default: st_d.rd_byte = st_q.rd_byte;
            endcase
            if (is_port && st_q.mode[MB_AINC])
                st_d.iaddr = st_q.iaddr + 1'b1;
        end else if (host_cs && !busy) begin
            if (is_port && st_q.mode[MB_AINC])
                st_d.iaddr = st_q.iaddr + 1'b1;
            unique case (kind)
                K_MODE: begin
                    if (host_wdata[MB_RST]) begin
                        st_d.mode    = 8'h80;
                        st_d.iaddr   = '0;
                        st_d.rst_cnt = CNT_W'(RST_CYCLES);
                        bank_clr     = 1'b1;
                    end else begin
                        st_d.mode = host_wdata & MODE_WMASK;
                    end
                end
                K_AHI:   st_d.iaddr[ADDR_W-1:8] = host_wdata[HI_W-1:0];
                K_ALO:   st_d.iaddr[7:0] = host_wdata;
                K_BANK:  bank_we = 1'b1;
                default: ext_we = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.rd_ext ? ext_rdata : st_q.rd_byte;
    assign ext_addr   = tgt;
    assign ext_wdata  = host_wdata;
    assign ping_block = st_q.mode[MB_NOPNG];
    assign core_rst   = busy;
endmodule

// File: rtl/hwb_checker.sv
module hwb_checker #(
    parameter int ADDR_W     = 15,
    parameter int BANK_BYTES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_cs,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_wdata,
    input logic              ext_re,
    input logic              ext_we,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [7:0]        mode,
    input logic [ADDR_W-1:0] iaddr,
    input logic              core_rst
);
    AST_EXT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_re && ext_we)); // R3
    AST_EXT_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_re || ext_we) |-> host_cs); // R3
    AST_EXT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_re || ext_we) |-> (ext_addr >= ADDR_W'(BANK_BYTES))); // R3
    AST_IDLE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !host_cs |=> $stable(iaddr)); // R5
    AST_AUTO_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && mode[0] && mode[1] && host_addr[1:0] == 2'd3 && !core_rst
         && !(host_we && host_wdata[7] && iaddr == '0))
        |=> (iaddr == ADDR_W'($past(iaddr) + 1'b1))); // R6
    AST_RESET_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> mode[7]); // R9
    AST_RESET_BIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> !mode[7]); // R9
endmodule

bind hostwin_bridge hwb_checker #(
    .ADDR_W     (ADDR_W),
    .BANK_BYTES (BANK_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_cs    (host_cs),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .ext_re     (ext_re),
    .ext_we     (ext_we),
    .ext_addr   (ext_addr),
    .mode       (st_q.mode),
    .iaddr      (st_q.iaddr),
    .core_rst   (core_rst)
);

// File: tb/sim_hostwin_bridge.sv
module sim_hostwin_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs = 1'b0;
    logic        host_we = 1'b0;
    logic [14:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        ext_re, ext_we;
    logic [14:0] ext_addr;
    logic [7:0]  ext_wdata;
    logic [7:0]  ext_rdata = '0;
    logic        ping_block, core_rst;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] envmem [4096];
    logic [7:0] gmem [4096];
    logic [7:0] gbank [64];
    logic [7:0] gmode;

    always #5 clk = ~clk;

    hostwin_bridge u0 (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ext_re(ext_re), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .ping_block(ping_block), .core_rst(core_rst)
    );

    // environment: synchronous byte memory, aliased on 12 address bits
    always @(posedge clk) begin
        if (ext_we) envmem[ext_addr[11:0]] <= ext_wdata;
        if (ext_re) ext_rdata <= envmem[ext_addr[11:0]];
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic golden_defaults();
        for (int i = 0; i < 64; i++) gbank[i] = 8'h00;
        gbank[23] = 8'h07;
        gbank[24] = 8'hD0;
        gmode = 8'h00;
    endtask

    function automatic logic [7:0] gexp(input logic [14:0] a);
        if (a == 15'd0) return gmode;
        else if (a < 15'd64) return gbank[a[5:0]];
        else return gmem[a[11:0]];
    endfunction

    task automatic gput(input logic [14:0] a, input logic [7:0] d);
        if (a == 15'd0) gmode = d & 8'h13;
        else if (a < 15'd64) gbank[a[5:0]] = d;
        else gmem[a[11:0]] = d;
    endtask

    // both tasks are entered at a falling edge and leave at the next one
    task automatic hwrite(input logic [14:0] a, input logic [7:0] d);
        host_cs = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_cs = 1'b0; host_we = 1'b0;
    endtask

    task automatic hread(input logic [14:0] a, output logic [7:0] d);
        host_cs = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_cs = 1'b0;
        d = host_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        for (int i = 0; i < 4096; i++) begin envmem[i] = 8'h00; gmem[i] = 8'h00; end
        golden_defaults();
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        hread(15'h0000, r); chk("R1 mode after reset", r, 8'h00);
        hread(15'h0017, r); chk("R1 retry high byte", r, 8'h07);
        hread(15'h0018, r); chk("R1 retry low byte", r, 8'hD0);
        chk("R9 core_rst idle after reset", {7'd0, core_rst}, 8'h00);

        // R2 mode bit masking and ping output
        hwrite(15'h0000, 8'h7C); gput(15'h0000, 8'h7C);
        hread(15'h0000, r); chk("R2 mode mask", r, 8'h10);
        chk("R2 ping_block follows bit 4", {7'd0, ping_block}, 8'h01);
        hwrite(15'h0000, 8'h00); gput(15'h0000, 8'h00);

        // R3 direct sweep: bank then external space
        for (int a = 1; a < 64; a++) begin
            hwrite(15'(a), 8'(a * 29 + 5)); gput(15'(a), 8'(a * 29 + 5));
        end
        for (int a = 1; a < 64; a++) begin
            hread(15'(a), r); chk("R3 direct bank", r, gexp(15'(a)));
        end
        for (int a = 64; a < 4096; a++) begin
            hwrite(15'(a), 8'(a * 13 + (a >> 8))); gput(15'(a), 8'(a * 13 + (a >> 8)));
        end
        for (int a = 64; a < 4096; a++) begin
            hread(15'(a), r); chk("R3 direct external", r, gexp(15'(a)));
        end
        hwrite(15'h7ABC, 8'h3C); gput(15'h7ABC, 8'h3C);
        hread(15'h7ABC, r); chk("R3 direct high address", r, 8'h3C);

        // R9 software reset from direct mode
        hwrite(15'h0000, 8'h80);
        chk("R9 core_rst raised", {7'd0, core_rst}, 8'h01);
        hread(15'h0000, r); chk("R9 bit 7 reads 1 during reset", r, 8'h80);
        hwrite(15'h0020, 8'h55);
        idle(2);
        chk("R9 core_rst dropped after 4 cycles", {7'd0, core_rst}, 8'h00);
        golden_defaults();
        hread(15'h0000, r); chk("R9 mode restored", r, 8'h00);
        hread(15'h0020, r); chk("R9 write during reset ignored", r, 8'h00);
        hread(15'h0017, r); chk("R9 retry high restored", r, 8'h07);
        hread(15'h0018, r); chk("R9 retry low restored", r, 8'hD0);

        // R4 address register in indirect mode
        hwrite(15'h0000, 8'h03); gput(15'h0000, 8'h03);
        hwrite(15'h0001, 8'hFF);
        hwrite(15'h0002, 8'h34);
        hread(15'h0001, r); chk("R4 high address byte", r, 8'h7F);
        hread(15'h0002, r); chk("R4 low address byte", r, 8'h34);
        hread(15'h0000, r); chk("R2 mode reachable in indirect", r, 8'h03);

        // R5 data port with auto-increment off
        hwrite(15'h0000, 8'h01); gput(15'h0000, 8'h01);
        hwrite(15'h0001, 8'h00); hwrite(15'h0002, 8'h17);
        hread(15'h0003, r); chk("R5 port read", r, 8'h07);
        hread(15'h0003, r); chk("R5 no increment", r, 8'h07);
        hread(15'h0002, r); chk("R5 address unchanged", r, 8'h17);

        // R6 auto-increment, big-endian pair
        hwrite(15'h0000, 8'h03); gput(15'h0000, 8'h03);
        hwrite(15'h0001, 8'h00); hwrite(15'h0002, 8'h17);
        hread(15'h0003, r); chk("R6 first byte high", r, 8'h07);
        hread(15'h0003, r); chk("R6 second byte low", r, 8'hD0);
        hread(15'h0002, r); chk("R6 address advanced by two", r, 8'h19);

        // R6 streamed port writes and reads
        hwrite(15'h0001, 8'h01); hwrite(15'h0002, 8'h00);
        for (int i = 0; i < 256; i++) begin
            hwrite(15'h0003, 8'(i ^ 8'h5A)); gput(15'(256 + i), 8'(i ^ 8'h5A));
        end
        hwrite(15'h0001, 8'h01); hwrite(15'h0002, 8'h00);
        for (int i = 0; i < 256; i++) begin
            hread(15'h0003, r); chk("R6 streamed port data", r, gexp(15'(256 + i)));
        end
        hread(15'h0001, r); chk("R6 stream end high", r, 8'h02);

        // R6 wrap from the top of the space onto the mode register
        hwrite(15'h0001, 8'h7F); hwrite(15'h0002, 8'hFF);
        hwrite(15'h0003, 8'hA5); gput(15'h7FFF, 8'hA5);
        hread(15'h0001, r); chk("R6 wrap high", r, 8'h00);
        hread(15'h0002, r); chk("R6 wrap low", r, 8'h00);
        hread(15'h0003, r); chk("R6 port at 0 is mode", r, 8'h03);
        hread(15'h0002, r); chk("R6 after wrap read", r, 8'h01);

        // R7 upper host bits ignored in indirect mode
        hwrite(15'h7FF1, 8'h02);
        hwrite(15'h1232, 8'h40);
        hread(15'h5552, r); chk("R7 low byte through aliased offset", r, 8'h40);
        hread(15'h7FF1, r); chk("R7 high byte through aliased offset", r, 8'h02);
        hwrite(15'h0001, 8'h02); hwrite(15'h0002, 8'h40);
        hread(15'h4443, r); chk("R7 port through aliased offset", r, gexp(15'h0240));

        // R8 address write then immediate port read
        hwrite(15'h0001, 8'h00);
        hwrite(15'h0002, 8'h18);
        hread(15'h0003, r); chk("R8 address used next cycle", r, 8'hD0);

        // R10 read data hold, external then local
        hwrite(15'h0001, 8'h7F); hwrite(15'h0002, 8'hFF);
        hread(15'h0003, r); chk("R10 external via port", r, 8'hA5);
        idle(3);
        chk("R10 external data held", host_rdata, 8'hA5);
        hread(15'h0000, r); chk("R10 local read", r, 8'h03);
        idle(3);
        chk("R10 local data held", host_rdata, 8'h03);

        // R9 software reset from indirect mode
        hwrite(15'h0000, 8'h83);
        hread(15'h0000, r); chk("R9 indirect reset bit", r, 8'h80);
        idle(5);
        golden_defaults();
        hread(15'h0000, r); chk("R9 back in direct mode", r, 8'h00);
        hwrite(15'h0000, 8'h01); gput(15'h0000, 8'h01);
        hread(15'h0001, r); chk("R9 address high cleared", r, 8'h00);
        hread(15'h0002, r); chk("R9 address low cleared", r, 8'h00);
        chk("R2 ping_block off after reset", {7'd0, ping_block}, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule